// File: doc/BRIEF.md
# Sized Load/Store Data Memory

This block is the data store used by the memory stage of a simple five-stage RISC pipeline. It holds 32-bit words. Reads and writes can be one byte, one halfword or a full word. The stage ahead of it has already added the sign-extended 16-bit offset to the base register, so the block receives a finished byte address. It also receives the store operand and a 3-bit access code taken from the low opcode bits.

A store of less than a word is merged into the word already held: only the selected byte lanes change. A load of less than a word picks the selected lanes and widens them to 32 bits, by sign or by zero, as the access code asks.

Addresses are little-endian byte addresses. The word index comes from the address bits just above the lane bits, and any higher bits are ignored. A store commits on the rising clock edge. A load is combinational from the address presented in the same cycle.

Top module: `ldst_ram`

## Requirements
- R1: A cycle with `rst_n` low at a rising edge clears every word to zero, so afterwards every load returns 0.
- R2: Access code 3 stores all 32 bits of `wdata` and loads all 32 bits unchanged. The word index is `addr[11:2]`; `addr[1:0]` and every bit above bit 11 are ignored.
- R3: Access code 0 (signed byte) returns byte lane `addr[1:0]` sign-extended. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R4: Access code 4 (unsigned byte) returns byte lane `addr[1:0]` with 24 leading zero bits.
- R5: Access code 1 (signed halfword) returns the halfword chosen by `addr[1]` (0 selects bits 15:0, 1 selects bits 31:16) sign-extended. `addr[0]` is ignored.
- R6: Access code 5 (unsigned halfword) returns the halfword chosen by `addr[1]` with 16 leading zero bits.
- R7: A byte store (code 0 or 4) writes `wdata[7:0]` into lane `addr[1:0]`. The other three bytes keep their values.
- R8: A halfword store (code 1 or 5) writes `wdata[15:0]` into the half chosen by `addr[1]`. The other half keeps its value.
- R9: A store takes effect at the rising edge. A load of the same word in the store's own cycle returns the old contents, and the cycle after returns the new contents.
- R10: While `rd_en` is low, `rdata` is 0.
- R11: Access codes 2, 6 and 7 are invalid: a store with them changes no word, and a load with them returns 0.
- R12: While `wr_en` is low, no word changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rst_n | input | 1 | Active-low synchronous clear of the whole array |
| addr | input | 32 | Byte address (base plus offset, already added) |
| wdata | input | 32 | Store operand; low lanes used for sub-word stores |
| acc_type | input | 3 | Access code: 0 byte, 1 half, 3 word, 4 unsigned byte, 5 unsigned half |
| rd_en | input | 1 | Load enable; `rdata` is zero when low |
| wr_en | input | 1 | Store enable |
| rdata | output | 32 | Load result, extended to 32 bits |

## Verification
The first phase fills 64 words with patterns whose bytes have both sign bits and both zero and non-zero upper halves. It then reads every one of them with each sub-word code at all four offsets, so a wrong lane, a wrong half or a wrong extension rule shows up as a different value. Word stores are issued with junk in the offset bits and in the bits above the index, to show that those bits are ignored. Byte and halfword stores cover every lane over a known background, which separates a correct merge from a full-word overwrite or a shifted lane. A write and a read of the same word in one cycle, the invalid codes, and both enables held low show the read-before-write ordering and that no stray write occurs.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = WORD_W / 8;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        ACC_SBYTE = 3'd0,
        ACC_SHALF = 3'd1,
        ACC_WORD  = 3'd3,
        ACC_UBYTE = 3'd4,
        ACC_UHALF = 3'd5
    } acc_kind_e;

    function automatic logic acc_valid(input logic [2:0] code);
        return (code == ACC_SBYTE) || (code == ACC_SHALF) || (code == ACC_WORD) ||
               (code == ACC_UBYTE) || (code == ACC_UHALF);
    endfunction

    function automatic logic acc_is_byte(input logic [2:0] code);
        return (code == ACC_SBYTE) || (code == ACC_UBYTE);
    endfunction

    function automatic logic acc_is_half(input logic [2:0] code);
        return (code == ACC_SHALF) || (code == ACC_UHALF);
    endfunction

endpackage

// File: rtl/ldst_store_merge.sv
module ldst_store_merge
    import ldst_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wdata,
    input  logic [2:0]        acc_type,
    input  logic [OFF_W-1:0]  off,
    output logic [WORD_W-1:0] new_word,
    output logic              type_ok
);

    logic [LANES-1:0] lane_hit;

    always_comb begin
        type_ok  = acc_valid(acc_type);
        lane_hit = '0;
        if (acc_type == ACC_WORD) begin
            lane_hit = '1;
        end else if (acc_is_half(acc_type)) begin
            lane_hit = off[1] ? 4'b1100 : 4'b0011;
        end else if (acc_is_byte(acc_type)) begin
            lane_hit = 4'b0001 << off;
        end
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [7:0] src_byte;
        always_comb begin
            if (acc_is_byte(acc_type)) begin
                src_byte = wdata[7:0];
            end else if (acc_is_half(acc_type)) begin
                src_byte = wdata[8*(ln%2) +: 8];
            end else begin
                src_byte = wdata[8*ln +: 8];
            end
            new_word[8*ln +: 8] = lane_hit[ln] ? src_byte : old_word[8*ln +: 8];
        end
    end

endmodule

// File: rtl/ldst_load_extend.sv
module ldst_load_extend
    import ldst_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [2:0]        acc_type,
    input  logic [OFF_W-1:0]  off,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rdata
);

    logic [7:0]        lane_byte [LANES];
    logic [7:0]        pick_byte;
    logic [15:0]       pick_half;
    logic [WORD_W-1:0] ext_word;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_split
        assign lane_byte[ln] = word[8*ln +: 8];
    end

    always_comb begin
        pick_byte = lane_byte[off];
        pick_half = off[1] ? word[31:16] : word[15:0];
        case (acc_type)
            ACC_SBYTE: ext_word = {{24{pick_byte[7]}}, pick_byte};
            ACC_UBYTE: ext_word = {24'd0, pick_byte};
            ACC_SHALF: ext_word = {{16{pick_half[15]}}, pick_half};
            ACC_UHALF: ext_word = {16'd0, pick_half};
            ACC_WORD:  ext_word = word;
            default:   ext_word = '0;
        endcase
        rdata = rd_en ? ext_word : '0;
    end

endmodule

// File: rtl/ldst_word_array.sv
module ldst_word_array
    import ldst_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rword
);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[idx] = wword;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rword = mem_q[idx];

endmodule

// File: rtl/ldst_ram.sv
module ldst_ram
    import ldst_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [2:0]        acc_type,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [31:0]       rdata
);

    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned IDX_LO = OFF_W;
    localparam int unsigned IDX_HI = OFF_W + IDX_W - 1;

    logic [IDX_W-1:0]  word_idx;
    logic [OFF_W-1:0]  lane_off;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] merged_word;
    logic              type_ok;
    logic              commit;
    logic              unused_addr_hi;

    assign word_idx       = addr[IDX_HI:IDX_LO];
    assign lane_off       = addr[OFF_W-1:0];
    assign unused_addr_hi = ^addr[ADDR_W-1:IDX_HI+1];
    assign commit         = wr_en && type_ok;

    ldst_word_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .idx   (word_idx),
        .wword (merged_word),
        .rword (cur_word)
    );

    ldst_store_merge u_merge (
        .old_word (cur_word),
        .wdata    (wdata),
        .acc_type (acc_type),
        .off      (lane_off),
        .new_word (merged_word),
        .type_ok  (type_ok)
    );

    ldst_load_extend u_extend (
        .word     (cur_word),
        .acc_type (acc_type),
        .off      (lane_off),
        .rd_en    (rd_en),
        .rdata    (rdata)
    );

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0); // R10
    AST_SBYTE_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && acc_type == ACC_SBYTE |-> rdata[31:8] == {24{rdata[7]}}); // R3
    AST_UBYTE_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && acc_type == ACC_UBYTE |-> rdata[31:8] == 24'd0); // R4
    AST_SHALF_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && acc_type == ACC_SHALF |-> rdata[31:16] == {16{rdata[15]}}); // R5
    AST_UHALF_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && acc_type == ACC_UHALF |-> rdata[31:16] == 16'd0); // R6
    AST_WORD_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_type == ACC_WORD |=>
        (!$stable(word_idx) || cur_word == $past(wdata))); // R2
    AST_BAD_CODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !acc_valid(acc_type) |=> (!$stable(word_idx) || $stable(cur_word))); // R11
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!$stable(word_idx) || $stable(cur_word))); // R12
    AST_BYTE_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_is_byte(acc_type) && lane_off == 2'd0 |=>
        (!$stable(addr) || cur_word[31:8] == $past(cur_word[31:8]))); // R7

endmodule

// File: tb/ldst_ram_tb.sv
module ldst_ram_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  acc_type = 3'd3;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [31:0] model [1024];

    always #10 clk = ~clk;

    ldst_ram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .acc_type(acc_type), .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata)
    );

    function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [1:0] off,
                                             input logic [2:0] t);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'((w >> (32'(off) * 8)) & 32'hFF);
        h = off[1] ? w[31:16] : w[15:0];
        case (t)
            3'd0: return {{24{b[7]}}, b};
            3'd4: return {24'd0, b};
            3'd1: return {{16{h[15]}}, h};
            3'd5: return {16'd0, h};
            3'd3: return w;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_store(input logic [31:0] w, input logic [31:0] d,
                                              input logic [1:0] off, input logic [2:0] t);
        logic [31:0] m;
        case (t)
            3'd0, 3'd4: m = 32'hFF << (32'(off) * 8);
            3'd1, 3'd5: m = off[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
            3'd3:       m = 32'hFFFF_FFFF;
            default:    m = 32'd0;
        endcase
        case (t)
            3'd0, 3'd4: d = {4{d[7:0]}};
            3'd1, 3'd5: d = {2{d[15:0]}};
            default:    d = d;
        endcase
        return (w & ~m) | (d & m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h code=%0d actual=%h expected=%h", req, addr, acc_type, act, exp);
        end
    endtask

    task automatic st(input logic [31:0] a, input logic [31:0] d, input logic [2:0] t,
                      input logic en = 1'b1);
        @(negedge clk);
        addr = a; wdata = d; acc_type = t; wr_en = en; rd_en = 1'b0;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (en) model[a[11:2]] = exp_store(model[a[11:2]], d, a[1:0], t);
    endtask

    task automatic ld(input string req, input logic [31:0] a, input logic [2:0] t);
        @(negedge clk);
        addr = a; acc_type = t; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        chk(req, rdata, exp_load(model[a[11:2]], a[1:0], t));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] sub_codes [4] = '{3'd0, 3'd1, 3'd4, 3'd5};
        for (int i = 0; i < 1024; i++) model[i] = '0;
        // R1: reset clears
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) ld("R1", 32'(i) * 64, 3'd3);

        // R2: word stores with junk offset and high bits
        for (int i = 0; i < 64; i++) begin
            logic [31:0] pat;
            pat = (32'(i) * 32'h9E37_79B9) ^ 32'h80FF_7F00;
            st((32'(i) << 2) | 32'(i % 4) | ((i % 2 == 1) ? 32'hA5A0_0000 : 32'h0), pat, 3'd3);
        end
        for (int i = 0; i < 64; i++) ld("R2", (32'(i) << 2) | 32'h0001_F000 | 32'((i + 1) % 4), 3'd3);

        // R3..R6: sub-word loads, every offset
        for (int i = 0; i < 64; i++) begin
            for (int off = 0; off < 4; off++) begin
                for (int k = 0; k < 4; k++) begin
                    case (sub_codes[k])
                        3'd0: ld("R3", (32'(i) << 2) | 32'(off), 3'd0);
                        3'd4: ld("R4", (32'(i) << 2) | 32'(off), 3'd4);
                        3'd1: ld("R5", (32'(i) << 2) | 32'(off), 3'd1);
                        default: ld("R6", (32'(i) << 2) | 32'(off), 3'd5);
                    endcase
                end
            end
        end

        // R7: byte stores into each lane over a known background
        for (int i = 64; i < 80; i++) begin
            st(32'(i) << 2, 32'h1122_3344 + 32'(i), 3'd3);
            st((32'(i) << 2) | 32'(i % 4), 32'hDEAD_BE00 | 32'(i * 7), (i % 2 == 0) ? 3'd0 : 3'd4);
            ld("R7", 32'(i) << 2, 3'd3);
        end
        // R8: halfword stores into each half, addr[0] junk
        for (int i = 80; i < 96; i++) begin
            st(32'(i) << 2, 32'hCAFE_F00D ^ 32'(i), 3'd3);
            st((32'(i) << 2) | 32'(i % 4), 32'h5A5A_0000 | 32'(i * 1111), (i % 2 == 0) ? 3'd1 : 3'd5);
            ld("R8", 32'(i) << 2, 3'd3);
        end

        // R9: read in the store's own cycle sees old data
        @(negedge clk);
        addr = 32'd5 << 2; wdata = 32'h0BAD_F00D; acc_type = 3'd3; wr_en = 1'b1; rd_en = 1'b1;
        #1;
        chk("R9", rdata, model[5]);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model[5] = 32'h0BAD_F00D;
        #1;
        chk("R9", rdata, 32'h0BAD_F00D);

        // R10: rd_en low forces zero
        @(negedge clk);
        addr = 32'd5 << 2; acc_type = 3'd3; rd_en = 1'b0;
        #1;
        chk("R10", rdata, 32'd0);

        // R11: invalid codes
        for (int c = 0; c < 3; c++) begin
            logic [2:0] bad;
            bad = (c == 0) ? 3'd2 : ((c == 1) ? 3'd6 : 3'd7);
            st(32'd7 << 2, 32'hFFFF_FFFF, bad, 1'b1);
            ld("R11", 32'd7 << 2, 3'd3);
            ld("R11", 32'd7 << 2, bad);
        end

        // R12: wr_en low leaves word intact
        st(32'd9 << 2, 32'h1357_9BDF, 3'd3, 1'b0);
        ld("R12", 32'd9 << 2, 3'd3);
        st(32'd10 << 2, 32'h0000_00EE, 3'd0, 1'b0);
        ld("R12", 32'd10 << 2, 3'd3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule